// File: doc/BRIEF.md
# Packed Command Stream Decoder

The decoder sits behind a DMA source that delivers 32-bit words. When no command is open, each accepted word is decoded as a command. The top byte is the opcode: bit 7 of it asks for an interrupt, and the low seven bits name the command. Bits 23:16 hold a count field. Unpack commands and a few other known commands open a payload. The words that follow are passed straight through to a downstream consumer until the payload length is used up. Illegal codes are thrown away.

Interrupt requests and illegal-code errors add to a pending-interrupt counter. Either source can be masked. Once the counter is non-zero and the open command's payload has been fully forwarded, the decoder stalls. It fetches no further command until a host clear pulse brings the counter back to zero.

Both stream ports use valid/ready handshakes. A word moves only on a cycle where both valid and ready are high. While a payload is open, `in_ready` follows `pl_ready`, so downstream back-pressure reaches the source in the same cycle. The payload data is never held inside the block. A source must keep `in_valid` and `in_data` steady until the word is taken. A consumer may lower `pl_ready` at any time.

Top module: `cmd_stream_decoder`

## Requirements
- R1: An opcode whose bits 6:5 are both 1 is an unpack command. Its payload length is the count field in bits 23:16 of the command word, where 0 stands for 256.
- R2: For a code that is not unpack, the payload length depends on the 7-bit code. Code 0x20 has 1 word. Codes 0x30 and 0x31 have 4 words. Code 0x4A has twice the count field, with a count of 0 meaning 512 words. Every other legal code (0x00 to 0x4A) has 0 words.
- R3: A non-unpack code above 0x4A is discarded and has no payload. With `err_mask` low, it sets the sticky `err_flag` and adds one to `irq_pending`. With `err_mask` high, it changes neither.
- R4: Opcode bit 7 with `irq_mask` low adds one to `irq_pending`. This adds to any count from R3 in the same command. With `irq_mask` high, the bit has no effect.
- R5: `stalled` is high exactly when `irq_pending` is non-zero and no payload is open. A payload that is open when the count rises is still forwarded in full first. While `stalled` is high, `in_ready` is low and no command word is taken.
- R6: When the decoder enters a stall, `stall_flag` is set, unless the command that caused the stall has the 7-bit code 0x07 (marker).
- R7: A one-cycle `irq_clear` lowers `irq_pending` by one and never takes it below zero. The same pulse clears `stall_flag`. When the count reaches zero, commands are taken again.
- R8: `status` reads as follows. 0 means idle. 1 means a command word is offered and will be taken. 2 means a payload is open and a word is offered. 3 means a payload is open and no word is offered.
- R9: While a payload is open, `pl_valid` equals `in_valid`, `pl_data` equals `in_data`, and `in_ready` equals `pl_ready`. When no payload is open, `pl_valid` is low.
- R10: `word_ofs` is the number of words accepted since reset, modulo 4. It holds its value through a stall.
- R11: After reset, no payload is open and the pending count, both flags, `word_ofs` and `status` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Source offers a word |
| in_data | input | 32 | Offered word |
| in_ready | output | 1 | Decoder takes the offered word this cycle |
| pl_valid | output | 1 | Payload word offered downstream |
| pl_data | output | 32 | Payload word |
| pl_ready | input | 1 | Consumer takes the payload word |
| err_mask | input | 1 | Suppresses illegal-code error reporting |
| irq_mask | input | 1 | Suppresses the per-command interrupt bit |
| irq_clear | input | 1 | Host pulse that retires one pending interrupt |
| status | output | 2 | Activity code (R8) |
| stalled | output | 1 | Decoder is stopped on a pending interrupt |
| stall_flag | output | 1 | Sticky flag for a non-marker stall |
| err_flag | output | 1 | Sticky flag for an illegal code |
| irq_pending | output | 4 | Pending-interrupt count |
| word_ofs | output | 2 | Word position within the current quadword |

## Verification
The assertions assume that the source holds each offered word stable until it is taken. They also assume that `irq_clear` is a single-cycle pulse that the host raises only to retire an interrupt. The stimulus changes inputs only on falling edges and holds a word until `in_ready` has been seen high. It pulses `irq_clear` for exactly one cycle, and only once a stall or a pending count has been observed. The masks are changed only between commands, never while a payload is open.

// File: rtl/cmd_stream_pkg.sv
package cmd_stream_pkg;
  localparam int WORD_W = 32;
  localparam int CODE_W = 7;

  localparam logic [CODE_W-1:0] LAST_LEGAL = 7'h4A;
  localparam logic [CODE_W-1:0] CODE_MARK  = 7'h07;
  localparam logic [CODE_W-1:0] CODE_ONE   = 7'h20;
  localparam logic [CODE_W-1:0] CODE_ROWV  = 7'h30;
  localparam logic [CODE_W-1:0] CODE_COLV  = 7'h31;
  localparam logic [CODE_W-1:0] CODE_DBL   = 7'h4A;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECODE = 2'd1,
    ST_XFER   = 2'd2,
    ST_WAIT   = 2'd3
  } status_e;
endpackage

// File: rtl/dsd_classify.sv
module dsd_classify
  import cmd_stream_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic [15:0]        cmd_hi,
  output logic [CODE_W-1:0]  code,
  output logic               irq_bit,
  output logic               is_illegal,
  output logic [LEN_W-1:0]   len
);
  logic [8:0] count;
  logic       is_unpack;

  assign code      = cmd_hi[14:8];
  assign irq_bit   = cmd_hi[15];
  assign count     = (cmd_hi[7:0] == 8'd0) ? 9'd256 : {1'b0, cmd_hi[7:0]};
  assign is_unpack = (code[6:5] == 2'b11);
  assign is_illegal = !is_unpack && (code > LAST_LEGAL);

  always_comb begin
    len = '0;
    if (is_unpack) begin
      len = LEN_W'(count);
    end else begin
      case (code)
        CODE_ONE:             len = LEN_W'(1);
        CODE_ROWV, CODE_COLV: len = LEN_W'(4);
        CODE_DBL:             len = LEN_W'({count, 1'b0});
        default:              len = '0;
      endcase
    end
  end
endmodule

// File: rtl/dsd_len_track.sv
module dsd_len_track
  import cmd_stream_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LEN_W-1:0]  load_len,
  input  logic [CODE_W-1:0] load_code,
  input  logic              step,
  output logic              active,
  output logic              last,
  output logic [CODE_W-1:0] cur_code
);
  logic [LEN_W-1:0] remaining;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remaining <= '0;
      cur_code  <= '0;
    end else if (load) begin
      remaining <= load_len;
      cur_code  <= load_code;
    end else if (step) begin
      remaining <= remaining - LEN_W'(1);
    end
  end

  assign active = (remaining != '0);
  assign last   = (remaining == LEN_W'(1));
endmodule

// File: rtl/dsd_irq_track.sv
module dsd_irq_track #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       inc,
  input  logic             clear,
  input  logic             end_evt,
  input  logic             not_marker,
  input  logic             err_set,
  output logic [CNT_W-1:0] pending,
  output logic             pend_zero,
  output logic             stall_flag,
  output logic             err_flag
);
  localparam int SUM_W = CNT_W + 2;
  localparam int MAX_I = (1 << CNT_W) - 1;
  localparam logic [SUM_W-1:0] MAX_V = SUM_W'(MAX_I);

  logic             dec;
  logic [SUM_W-1:0] sum;
  logic [CNT_W-1:0] pend_nx;
  logic             stall_evt;

  assign pend_zero = (pending == '0);
  assign dec       = clear && !pend_zero;
  assign sum       = SUM_W'(pending) + SUM_W'(inc) - SUM_W'(dec);
  assign pend_nx   = (sum > MAX_V) ? MAX_V[CNT_W-1:0] : sum[CNT_W-1:0];
  assign stall_evt = end_evt && not_marker && (sum != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending    <= '0;
      stall_flag <= 1'b0;
      err_flag   <= 1'b0;
    end else begin
      pending <= pend_nx;
      if (stall_evt)  stall_flag <= 1'b1;
      else if (clear) stall_flag <= 1'b0;
      if (err_set)    err_flag   <= 1'b1;
    end
  end
endmodule

// File: rtl/dsd_status.sv
module dsd_status
  import cmd_stream_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       in_valid,
  input  logic       pend_zero,
  input  logic       hs,
  output logic [1:0] status,
  output logic [1:0] word_ofs
);
  status_e st;

  always_comb begin
    if (active)                      st = in_valid ? ST_XFER : ST_WAIT;
    else if (in_valid && pend_zero)  st = ST_DECODE;
    else                             st = ST_IDLE;
  end
  assign status = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  word_ofs <= 2'd0;
    else if (hs) word_ofs <= word_ofs + 2'd1;
  end
endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
  import cmd_stream_pkg::*;
#(
  parameter int LEN_W = 10,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      in_data,
  output logic             in_ready,
  output logic             pl_valid,
  output logic [31:0]      pl_data,
  input  logic             pl_ready,
  input  logic             err_mask,
  input  logic             irq_mask,
  input  logic             irq_clear,
  output logic [1:0]       status,
  output logic             stalled,
  output logic             stall_flag,
  output logic             err_flag,
  output logic [CNT_W-1:0] irq_pending,
  output logic [1:0]       word_ofs
);
  logic [CODE_W-1:0] dec_code, cur_code, evt_code;
  logic              dec_irq, dec_illegal;
  logic [LEN_W-1:0]  dec_len;
  logic              active, last, pend_zero;
  logic              cmd_fire, pl_fire, end_evt, err_hit, irq_hit;
  logic [1:0]        inc;

  dsd_classify #(.LEN_W(LEN_W)) u_cls (
    .cmd_hi     (in_data[31:16]),
    .code       (dec_code),
    .irq_bit    (dec_irq),
    .is_illegal (dec_illegal),
    .len        (dec_len)
  );

  assign cmd_fire = !active && pend_zero && in_valid;
  assign pl_valid = active && in_valid;
  assign pl_data  = in_data;
  assign pl_fire  = pl_valid && pl_ready;
  assign in_ready = active ? pl_ready : pend_zero;
  assign stalled  = !active && !pend_zero;

  assign err_hit  = cmd_fire && dec_illegal && !err_mask;
  assign irq_hit  = cmd_fire && dec_irq && !irq_mask;
  assign inc      = {1'b0, err_hit} + {1'b0, irq_hit};
  assign end_evt  = (cmd_fire && (dec_len == '0)) || (pl_fire && last);
  assign evt_code = cmd_fire ? dec_code : cur_code;

  dsd_len_track #(.LEN_W(LEN_W)) u_len (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cmd_fire),
    .load_len  (dec_len),
    .load_code (dec_code),
    .step      (pl_fire),
    .active    (active),
    .last      (last),
    .cur_code  (cur_code)
  );

  dsd_irq_track #(.CNT_W(CNT_W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc        (inc),
    .clear      (irq_clear),
    .end_evt    (end_evt),
    .not_marker (evt_code != CODE_MARK),
    .err_set    (err_hit),
    .pending    (irq_pending),
    .pend_zero  (pend_zero),
    .stall_flag (stall_flag),
    .err_flag   (err_flag)
  );

  dsd_status u_st (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .in_valid  (in_valid),
    .pend_zero (pend_zero),
    .hs        (in_valid && in_ready),
    .status    (status),
    .word_ofs  (word_ofs)
  );
endmodule

// File: rtl/cmd_stream_decoder_chk.sv
module cmd_stream_decoder_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [31:0]      in_data,
  input logic             in_ready,
  input logic             pl_valid,
  input logic [31:0]      pl_data,
  input logic             irq_clear,
  input logic [1:0]       status,
  input logic             stalled,
  input logic             err_flag,
  input logic [CNT_W-1:0] irq_pending,
  input logic [1:0]       word_ofs
);
  // R5
  no_fetch_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |-> !in_ready);

  // R9
  payload_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pl_valid |-> (in_valid && pl_data == in_data));

  // R7
  pending_only_falls_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_clear |=> (irq_pending >= $past(irq_pending)));

  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R10
  ofs_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (word_ofs == $past(word_ofs) + 2'd1));

  // R10
  ofs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(word_ofs));

  // R8
  decode_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd1) |-> (in_ready && !pl_valid));
endmodule

bind cmd_stream_decoder cmd_stream_decoder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_data     (in_data),
  .in_ready    (in_ready),
  .pl_valid    (pl_valid),
  .pl_data     (pl_data),
  .irq_clear   (irq_clear),
  .status      (status),
  .stalled     (stalled),
  .err_flag    (err_flag),
  .irq_pending (irq_pending),
  .word_ofs    (word_ofs)
);

// File: tb/test_cmd_stream_decoder.sv
`timescale 1ns/1ps
module test_cmd_stream_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        pl_valid;
  logic [31:0] pl_data;
  logic        pl_ready = 1'b1;
  logic        err_mask = 1'b0;
  logic        irq_mask = 1'b0;
  logic        irq_clear = 1'b0;
  logic [1:0]  status;
  logic        stalled, stall_flag, err_flag;
  logic [3:0]  irq_pending;
  logic [1:0]  word_ofs;

  int checks = 0;
  int errors = 0;
  int ofs = 0;

  always #10 clk = ~clk;

  cmd_stream_decoder i_cmd_stream_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .pl_valid(pl_valid), .pl_data(pl_data),
    .pl_ready(pl_ready), .err_mask(err_mask), .irq_mask(irq_mask),
    .irq_clear(irq_clear), .status(status), .stalled(stalled),
    .stall_flag(stall_flag), .err_flag(err_flag),
    .irq_pending(irq_pending), .word_ofs(word_ofs)
  );

  localparam int NV = 18;
  localparam logic [31:0] V_CMD [NV] = '{
    32'h00000000, 32'h20000000, 32'h30000000, 32'h31000000,
    32'h4A030000, 32'h6C050000, 32'h7F020000, 32'h60000000,
    32'h4B000000, 32'h94000000, 32'hB1000000, 32'h87000000,
    32'h94000000, 32'hE2030000, 32'h4B000000, 32'hDF000000,
    32'h5F000000, 32'h4A000000};
  localparam int V_EM   [NV] = '{0,0,0,0,0,0,0,0,1,0,0,0,0,0,0,0,1,0};
  localparam int V_IM   [NV] = '{0,0,0,0,0,0,0,0,0,1,1,0,0,0,0,0,1,0};
  localparam int V_LEN  [NV] = '{0,1,4,4,6,5,2,256,0,0,4,0,0,3,0,0,0,512};
  localparam int V_PEND [NV] = '{0,0,0,0,0,0,0,0,0,0,0,1,1,1,1,2,0,0};
  localparam int V_SFL  [NV] = '{0,0,0,0,0,0,0,0,0,0,0,0,1,1,1,1,0,0};
  localparam int V_ERR  [NV] = '{0,0,0,0,0,0,0,0,0,0,0,0,0,0,1,1,1,1};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Starts and ends at a falling edge with in_valid low.
  task automatic push(input logic [31:0] w, output bit ok, output bit was_pl);
    ok = 1'b0;
    was_pl = 1'b0;
    in_valid = 1'b1;
    in_data = w;
    for (int k = 0; k < 40; k++) begin
      #1;
      if (in_ready) begin
        ok = 1'b1;
        was_pl = pl_valid;
        break;
      end
      @(negedge clk);
    end
    if (ok) begin
      @(negedge clk);
      ofs = (ofs + 1) % 4;
    end
    in_valid = 1'b0;
  endtask

  task automatic pulse_clear();
    irq_clear = 1'b1;
    @(negedge clk);
    irq_clear = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ok, was;
    int npl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R11 reset state
    chk(in_ready == 1'b1 && pl_valid == 1'b0, "R11 ready/valid", {in_ready, pl_valid}, 2);
    chk(status == 2'd0, "R11 status", status, 0);
    chk(irq_pending == 0 && !stall_flag && !err_flag, "R11 counters",
        {irq_pending, stall_flag, err_flag}, 0);
    chk(word_ofs == 2'd0 && !stalled, "R11 offset/stall", {word_ofs, stalled}, 0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      err_mask = V_EM[i][0];
      irq_mask = V_IM[i][0];
      push(V_CMD[i], ok, was);
      chk(ok, "R5 command accepted", ok, 1);
      npl = 0;
      for (int k = 0; k < V_LEN[i]; k++) begin
        push(32'hA5000000 | k, ok, was);
        if (ok && was) npl++;
      end
      #1;
      // R1/R2/R3 payload length per opcode
      chk(npl == V_LEN[i], "R1/R2 payload words", npl, V_LEN[i]);
      chk(status == 2'd0, "R8 idle after payload", status, 0);
      chk(irq_pending == V_PEND[i], "R3/R4 pending count", irq_pending, V_PEND[i]);
      chk(stall_flag == V_SFL[i][0], "R6 stall flag", stall_flag, V_SFL[i]);
      chk(err_flag == V_ERR[i][0], "R3 error flag", err_flag, V_ERR[i]);
      chk(stalled == (V_PEND[i] != 0), "R5 stalled", stalled, V_PEND[i] != 0);
      chk(word_ofs == ofs, "R10 word offset", word_ofs, ofs);
      @(negedge clk);
      if (V_PEND[i] != 0) begin
        for (int c = 0; c < V_PEND[i]; c++) pulse_clear();
        #1;
        chk(irq_pending == 0 && !stall_flag, "R7 clear retires",
            {irq_pending, stall_flag}, 0);
        chk(in_ready && !stalled, "R7 resume", {in_ready, stalled}, 2);
        @(negedge clk);
      end
    end
    err_mask = 1'b0;
    irq_mask = 1'b0;

    // R8/R9 back-pressure and status codes
    in_valid = 1'b1;
    in_data = 32'h30000000;
    #1;
    chk(status == 2'd1, "R8 decode status", status, 1);
    @(negedge clk);
    ofs = (ofs + 1) % 4;
    in_data = 32'h11112222;
    pl_ready = 1'b0;
    #1;
    chk(!in_ready && pl_valid, "R9 back-pressure", {in_ready, pl_valid}, 1);
    chk(pl_data == 32'h11112222, "R9 payload data", pl_data, 32'h11112222);
    chk(status == 2'd2, "R8 transfer status", status, 2);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(status == 2'd3, "R8 wait status", status, 3);
    chk(word_ofs == ofs, "R10 no advance under back-pressure", word_ofs, ofs);
    pl_ready = 1'b1;
    @(negedge clk);
    npl = 0;
    for (int k = 0; k < 4; k++) begin
      push(32'h5A5A0000 | k, ok, was);
      if (ok && was) npl++;
    end
    #1;
    chk(npl == 4, "R2 payload after back-pressure", npl, 4);
    @(negedge clk);

    // R5 stall deferred until the payload is forwarded
    push(32'hE2020000, ok, was);
    #1;
    chk(irq_pending == 1 && !stalled, "R5 deferred stall", {irq_pending, stalled}, 2);
    chk(status == 2'd3, "R8 open payload wait", status, 3);
    @(negedge clk);
    push(32'h00000001, ok, was);
    #1;
    chk(!stalled, "R5 still forwarding", stalled, 0);
    @(negedge clk);
    push(32'h00000002, ok, was);
    #1;
    chk(stalled && stall_flag, "R6 stall on last word", {stalled, stall_flag}, 3);
    @(negedge clk);
    in_valid = 1'b1;
    in_data = 32'h20000000;
    #1;
    chk(!in_ready && !pl_valid, "R5 no fetch while stalled", {in_ready, pl_valid}, 0);
    chk(status == 2'd0, "R8 stalled reads idle", status, 0);
    repeat (3) @(negedge clk);
    #1;
    chk(word_ofs == ofs, "R10 offset held in stall", word_ofs, ofs);
    in_valid = 1'b0;
    @(negedge clk);
    pulse_clear();
    #1;
    chk(irq_pending == 0 && !stalled && !stall_flag, "R7 release",
        {irq_pending, stalled, stall_flag}, 0);
    @(negedge clk);
    pulse_clear();
    #1;
    chk(irq_pending == 0, "R7 no underflow", irq_pending, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule